// File: doc/BRIEF.md
# USB Controller Interrupt and Control Register Wrapper

This block sits between a dual-role USB controller core and a processor's 32-bit register port. The core reports events as single-cycle pulses: endpoint events on a 32-bit vector and core-level events on a 9-bit vector. The wrapper latches each pulse into a pending status bit. It gates the pending bits with per-bit enable masks and merges the result into one interrupt request line. Software reads a status word and writes the same value back to acknowledge it. Enables are never written directly. They are raised through a set register and lowered through a clear register, so two agents can change different bits without a read-modify-write race.

The endpoint word packs transmit endpoints 0 to 15 into bits 15:0 and receive endpoints 1 to 15 into bits 31:17. Bit 16 has no receive endpoint 0 behind it and always reads zero. Core events occupy bits 8:0, and bit 8 is the VBUS-drive event.

The wrapper also holds three control functions:
- A self-timed reset pulse for the controller core.
- An OTG-disable control for the PHY.
- An ID-pin override, which lets software force host or peripheral role in place of the external ID pin.

Top module: `usb_irq_wrap`

## Requirements
- R1: Offset 0x00 reads the nonzero parameter REV_ID. Any offset outside the map (0x00, 0x14, 0x18, 0x30, 0x34, 0x38, 0x3C, 0x40, 0x44, 0xE0, 0xE8) reads zero.
- R2: An event pulse on epEvent[i] or coreEvent[i] sets pending bit i. The endpoint status word reads at 0x30 and the core status word reads at 0x34. Endpoint bit 16 always reads 0, and core status bits 31:9 always read 0.
- R3: Writing the endpoint status (0x30) or core status (0x34) word clears each pending bit written as 1. Bits written as 0 keep their value.
- R4: When an event pulse and a write-one clear reach the same pending bit in the same cycle, the bit ends up set.
- R5: A 1 written to endpoint set (0x38) or core set (0x3C) enables that bit. A 1 written to endpoint clear (0x40) or core clear (0x44) disables it. Bits written as 0 change nothing. Both the set and clear offsets of a word read back its current enable mask.
- R6: irqOut is high exactly when some pending bit is also enabled. It follows a write or event one cycle later. Bit 0 of offset 0x18 reads irqOut, and the other bits of 0x18 read 0.
- R7: Writing 1 to bit 0 of offset 0x14 drives coreRstOut high for exactly RST_CYCLES cycles, starting the cycle after the write. Bit 0 of 0x14 reads 1 during the pulse and 0 afterwards. A write made while the pulse is running does not extend it.
- R8: Bit 21 of offset 0xE0 is stored, read back and driven on otgDisable. All other bits of 0xE0 read 0.
- R9: Bit 7 (override) and bit 8 (ID value) of offset 0xE8 are stored and read back, and other bits read 0. idSel equals bit 8 when bit 7 is 1 and equals idPin when bit 7 is 0.
- R10: After reset, all status, enable, control, PHY and mode bits are 0, and irqOut and coreRstOut are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| epEvent | input | 32 | Endpoint event pulses (tx 15:0, rx 31:17) |
| coreEvent | input | 9 | Core event pulses |
| idPin | input | 1 | External ID pin level |
| irqOut | output | 1 | Combined interrupt request |
| coreRstOut | output | 1 | Reset pulse to the controller core |
| otgDisable | output | 1 | PHY OTG-disable control |
| idSel | output | 1 | ID value presented to the core |

## Verification
The bench targets four cases.
- Same-cycle collision: an event and a write-one clear hit the same bit. A design that lets the clear win silently drops an interrupt.
- Bit 16 of the endpoint word: it is driven with events and written through the set register, and must never read as 1.
- Write-one semantics: random masks with many zero bits go to the status, set and clear registers. A design that treated any of them as a plain store would wipe unrelated bits.
- Reset pulse length: it is counted cycle by cycle. An off-by-one counter, or a pulse that never self-clears, shows up at once.

// File: rtl/usbw_pkg.sv
package usbw_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_REV   = 8'h00;
  localparam logic [ADDR_W-1:0] A_CTRL  = 8'h14;
  localparam logic [ADDR_W-1:0] A_STAT  = 8'h18;
  localparam logic [ADDR_W-1:0] A_EPST  = 8'h30;
  localparam logic [ADDR_W-1:0] A_CRST  = 8'h34;
  localparam logic [ADDR_W-1:0] A_EPSET = 8'h38;
  localparam logic [ADDR_W-1:0] A_CRSET = 8'h3C;
  localparam logic [ADDR_W-1:0] A_EPCLR = 8'h40;
  localparam logic [ADDR_W-1:0] A_CRCLR = 8'h44;
  localparam logic [ADDR_W-1:0] A_PHY   = 8'hE0;
  localparam logic [ADDR_W-1:0] A_MODE  = 8'hE8;

  localparam int CTRL_RST_BIT  = 0;
  localparam int PHY_OTGD_BIT  = 21;
  localparam int MODE_IDV_BIT  = 8;
  localparam int MODE_IDM_BIT  = 7;

  // endpoint word: rx endpoint 0 slot (bit 16) does not exist
  localparam logic [DATA_W-1:0] EP_VALID = 32'hFFFE_FFFF;

  typedef enum logic [3:0] {
    RD_NONE, RD_REV, RD_CTRL, RD_STAT, RD_EPST, RD_CRST,
    RD_EPEN, RD_CREN, RD_PHY, RD_MODE
  } rdSel_e;

  typedef struct packed {
    logic ctrl;
    logic epStat;
    logic coreStat;
    logic epSet;
    logic coreSet;
    logic epClr;
    logic coreClr;
    logic phy;
    logic mode;
  } wrStb_t;

endpackage

// File: rtl/usbw_ctrl.sv
module usbw_ctrl
  import usbw_pkg::*;
(
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output wrStb_t            wrStb,
  output rdSel_e            rdSel
);

  always_comb begin
    wrStb = '0;
    rdSel = RD_NONE;
    unique case (regAddr)
      A_REV:   rdSel = RD_REV;
      A_CTRL:  begin rdSel = RD_CTRL; wrStb.ctrl     = regWr; end
      A_STAT:  rdSel = RD_STAT;
      A_EPST:  begin rdSel = RD_EPST; wrStb.epStat   = regWr; end
      A_CRST:  begin rdSel = RD_CRST; wrStb.coreStat = regWr; end
      A_EPSET: begin rdSel = RD_EPEN; wrStb.epSet    = regWr; end
      A_CRSET: begin rdSel = RD_CREN; wrStb.coreSet  = regWr; end
      A_EPCLR: begin rdSel = RD_EPEN; wrStb.epClr    = regWr; end
      A_CRCLR: begin rdSel = RD_CREN; wrStb.coreClr  = regWr; end
      A_PHY:   begin rdSel = RD_PHY;  wrStb.phy      = regWr; end
      A_MODE:  begin rdSel = RD_MODE; wrStb.mode     = regWr; end
      default: rdSel = RD_NONE;
    endcase
  end

endmodule

// File: rtl/usbw_irq_bank.sv
module usbw_irq_bank #(
  parameter int           W     = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] evt,
  input  logic         wStat,
  input  logic         wSet,
  input  logic         wClr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] stat,
  output logic [W-1:0] en,
  output logic         req
);

  logic [W-1:0] clrMask;

  assign clrMask = wStat ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stat <= '0;
      en   <= '0;
    end else begin
      // a new event takes precedence over a same-cycle acknowledge
      stat <= ((stat & ~clrMask) | evt) & VALID;
      if (wSet)      en <= (en | wdata) & VALID;
      else if (wClr) en <= en & ~wdata;
    end
  end

  assign req = |(stat & en);

endmodule

// File: rtl/usbw_datapath.sv
module usbw_datapath
  import usbw_pkg::*;
#(
  parameter logic [DATA_W-1:0] REV_ID     = 32'h4EA2_0800,
  parameter int                RST_CYCLES = 4,
  parameter int                CORE_W     = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStb_t            wrStb,
  input  rdSel_e            rdSel,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] epEvent,
  input  logic [CORE_W-1:0] coreEvent,
  input  logic              idPin,
  output logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] epStat,
  output logic [DATA_W-1:0] epEn,
  output logic [CORE_W-1:0] coreStat,
  output logic [CORE_W-1:0] coreEn,
  output logic              irqOut,
  output logic              coreRstOut,
  output logic              otgDisable,
  output logic              idSel
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

  logic              epReq, coreReq;
  logic [CNT_W-1:0]  rstCnt;
  logic              modeIdVal, modeIdMux;

  usbw_irq_bank #(.W(DATA_W), .VALID(EP_VALID)) uEpBank (
    .clk(clk), .rstN(rstN), .evt(epEvent),
    .wStat(wrStb.epStat), .wSet(wrStb.epSet), .wClr(wrStb.epClr),
    .wdata(regWdata), .stat(epStat), .en(epEn), .req(epReq)
  );

  usbw_irq_bank #(.W(CORE_W), .VALID({CORE_W{1'b1}})) uCoreBank (
    .clk(clk), .rstN(rstN), .evt(coreEvent),
    .wStat(wrStb.coreStat), .wSet(wrStb.coreSet), .wClr(wrStb.coreClr),
    .wdata(regWdata[CORE_W-1:0]), .stat(coreStat), .en(coreEn), .req(coreReq)
  );

  assign irqOut = epReq | coreReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstCnt <= '0;
    end else if (rstCnt != '0) begin
      rstCnt <= rstCnt - 1'b1;
    end else if (wrStb.ctrl && regWdata[CTRL_RST_BIT]) begin
      rstCnt <= CNT_LOAD;
    end
  end

  assign coreRstOut = (rstCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      otgDisable <= 1'b0;
      modeIdVal  <= 1'b0;
      modeIdMux  <= 1'b0;
    end else begin
      if (wrStb.phy) otgDisable <= regWdata[PHY_OTGD_BIT];
      if (wrStb.mode) begin
        modeIdVal <= regWdata[MODE_IDV_BIT];
        modeIdMux <= regWdata[MODE_IDM_BIT];
      end
    end
  end

  assign idSel = modeIdMux ? modeIdVal : idPin;

  always_comb begin
    regRdata = '0;
    unique case (rdSel)
      RD_REV:  regRdata = REV_ID;
      RD_CTRL: regRdata[CTRL_RST_BIT] = coreRstOut;
      RD_STAT: regRdata[0] = irqOut;
      RD_EPST: regRdata = epStat;
      RD_CRST: regRdata[CORE_W-1:0] = coreStat;
      RD_EPEN: regRdata = epEn;
      RD_CREN: regRdata[CORE_W-1:0] = coreEn;
      RD_PHY:  regRdata[PHY_OTGD_BIT] = otgDisable;
      RD_MODE: begin
        regRdata[MODE_IDV_BIT] = modeIdVal;
        regRdata[MODE_IDM_BIT] = modeIdMux;
      end
      default: regRdata = '0;
    endcase
  end

endmodule

// File: rtl/usb_irq_wrap.sv
module usb_irq_wrap
  import usbw_pkg::*;
#(
  parameter logic [31:0] REV_ID     = 32'h4EA2_0800,
  parameter int          RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic [31:0] epEvent,
  input  logic [8:0]  coreEvent,
  input  logic        idPin,
  output logic        irqOut,
  output logic        coreRstOut,
  output logic        otgDisable,
  output logic        idSel
);

  wrStb_t      wrStb;
  rdSel_e      rdSel;
  logic [31:0] epStat, epEn;
  logic [8:0]  coreStat, coreEn;

  usbw_ctrl uCtrl (
    .regWr(regWr), .regAddr(regAddr), .wrStb(wrStb), .rdSel(rdSel)
  );

  usbw_datapath #(.REV_ID(REV_ID), .RST_CYCLES(RST_CYCLES), .CORE_W(9)) uDp (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdSel(rdSel),
    .regWdata(regWdata), .epEvent(epEvent), .coreEvent(coreEvent),
    .idPin(idPin), .regRdata(regRdata), .epStat(epStat), .epEn(epEn),
    .coreStat(coreStat), .coreEn(coreEn), .irqOut(irqOut),
    .coreRstOut(coreRstOut), .otgDisable(otgDisable), .idSel(idSel)
  );

endmodule

// File: rtl/usbw_chk.sv
module usbw_chk #(
  parameter int RST_CYCLES = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        regWr,
  input logic [7:0]  regAddr,
  input logic [31:0] regWdata,
  input logic [31:0] epEvent,
  input logic [31:0] epStat,
  input logic [31:0] epEn,
  input logic        irqOut,
  input logic        coreRstOut
);

  localparam logic [31:0] EPM = 32'hFFFE_FFFF;

  logic [15:0] hiCnt;

  always_ff @(posedge clk) begin
    if (!rstN)           hiCnt <= '0;
    else if (coreRstOut) hiCnt <= hiCnt + 16'd1;
    else                 hiCnt <= '0;
  end

  // R2
  ep_bit16_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (epStat[16] == 1'b0 && epEn[16] == 1'b0));

  // R4
  evt_beats_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 8'h30 && (regWdata & epEvent & EPM) != 32'h0)
    |=> ((epStat & $past(regWdata & epEvent & EPM)) == $past(regWdata & epEvent & EPM)));

  // R5
  en_rise_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((epEn & ~$past(epEn)) != 32'h0) |-> $past(regWr && regAddr == 8'h38));

  // R6
  irq_fall_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(regWr));

  // R7
  rst_rise_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreRstOut) |-> $past(regWr && regAddr == 8'h14 && regWdata[0]));

  // R7
  rst_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreRstOut) |-> (hiCnt == 16'(RST_CYCLES)));

endmodule

bind usb_irq_wrap usbw_chk #(.RST_CYCLES(RST_CYCLES)) uChk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
  .regWdata(regWdata), .epEvent(epEvent), .epStat(epStat), .epEn(epEn),
  .irqOut(irqOut), .coreRstOut(coreRstOut)
);

// File: tb/sim_usb_irq_wrap.sv
`timescale 1ns/1ps
module sim_usb_irq_wrap;

  localparam logic [31:0] REV = 32'h4EA2_0800;
  localparam int          RSTN = 4;
  localparam logic [31:0] EPM = 32'hFFFE_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWdata = 32'h0;
  logic [31:0] regRdata;
  logic [31:0] epEvent = 32'h0;
  logic [8:0]  coreEvent = 9'h0;
  logic        idPin = 1'b0;
  logic        irqOut, coreRstOut, otgDisable, idSel;

  int total = 0;
  int bad = 0;

  logic [31:0] mEp, mEpEn;
  logic [8:0]  mCr, mCrEn;

  always #2.5 clk = ~clk;

  usb_irq_wrap #(.REV_ID(REV), .RST_CYCLES(RSTN)) u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .epEvent(epEvent),
    .coreEvent(coreEvent), .idPin(idPin), .irqOut(irqOut),
    .coreRstOut(coreRstOut), .otgDisable(otgDisable), .idSel(idSel)
  );

  function automatic logic expIrq(input logic [31:0] s, input logic [31:0] e,
                                  input logic [8:0] cs, input logic [8:0] ce);
    return (|(s & e)) | (|(cs & ce));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    regAddr = a;
    #0.2;
    v = regRdata;
  endtask

  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [31:0] ev, input logic [8:0] cev);
    @(negedge clk);
    regWr = wr; regAddr = a; regWdata = d; epEvent = ev; coreEvent = cev;
    @(posedge clk);
    mEp = ((mEp & ~((wr && a == 8'h30) ? d : 32'h0)) | ev) & EPM;
    mCr = (mCr & ~((wr && a == 8'h34) ? d[8:0] : 9'h0)) | cev;
    if (wr && a == 8'h38) mEpEn = (mEpEn | d) & EPM;
    if (wr && a == 8'h40) mEpEn = mEpEn & ~d;
    if (wr && a == 8'h3C) mCrEn = mCrEn | d[8:0];
    if (wr && a == 8'h44) mCrEn = mCrEn & ~d[8:0];
    #0.5;
    regWr = 1'b0; epEvent = 32'h0; coreEvent = 9'h0;
  endtask

  task automatic verify(input string tag);
    logic [31:0] v;
    @(negedge clk);
    rd(8'h30, v); chk({tag, " R2 R3 ep status"}, v, mEp);
    rd(8'h34, v); chk({tag, " R2 R3 core status"}, v, {23'h0, mCr});
    rd(8'h38, v); chk({tag, " R5 ep en via set"}, v, mEpEn);
    rd(8'h40, v); chk({tag, " R5 ep en via clr"}, v, mEpEn);
    rd(8'h3C, v); chk({tag, " R5 core en via set"}, v, {23'h0, mCrEn});
    rd(8'h44, v); chk({tag, " R5 core en via clr"}, v, {23'h0, mCrEn});
    rd(8'h18, v); chk({tag, " R6 status reg"}, v, {31'h0, expIrq(mEp, mEpEn, mCr, mCrEn)});
    chk({tag, " R6 irqOut"}, {31'h0, irqOut}, {31'h0, expIrq(mEp, mEpEn, mCr, mCrEn)});
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int hi;
    mEp = '0; mEpEn = '0; mCr = '0; mCrEn = '0;
    void'($urandom(32'd5150));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state, R1 revision
    rd(8'h00, v); chk("R1 revision", v, REV);
    chk("R1 revision nonzero", {31'h0, (v != 32'h0)}, 32'h1);
    rd(8'h14, v); chk("R10 ctrl", v, 32'h0);
    rd(8'hE0, v); chk("R10 phy", v, 32'h0);
    rd(8'hE8, v); chk("R10 mode", v, 32'h0);
    chk("R10 outputs", {28'h0, irqOut, coreRstOut, otgDisable, idSel}, 32'h0);
    rstN = 1'b1;
    verify("R10 post-reset");
    rd(8'h04, v); chk("R1 unmapped 0x04", v, 32'h0);
    rd(8'hFC, v); chk("R1 unmapped 0xFC", v, 32'h0);

    // R2 bit 16 never sets, even when set-enabled
    step(1'b1, 8'h38, 32'hFFFF_FFFF, 32'h0001_0000, 9'h0);
    verify("R2 bit16");
    step(1'b1, 8'h40, 32'hFFFF_FFFF, 32'h0, 9'h0);

    // R4 collision: event and clear on same bit
    step(1'b0, 8'h00, 32'h0, 32'h0000_0008, 9'h100);
    step(1'b1, 8'h30, 32'h0000_0008, 32'h0000_0008, 9'h0);
    @(negedge clk);
    rd(8'h30, v); chk("R4 ep event beats clear", v & 32'h8, 32'h8);
    step(1'b1, 8'h34, 32'h0000_0100, 32'h0, 9'h100);
    @(negedge clk);
    rd(8'h34, v); chk("R4 core event beats clear", v & 32'h100, 32'h100);
    verify("R4 model");

    // R6 irq raise and drop timing via enable then clear
    step(1'b1, 8'h3C, 32'h0000_0100, 32'h0, 9'h0);
    chk("R6 irq one cycle after enable", {31'h0, irqOut}, 32'h1);
    step(1'b1, 8'h34, 32'h0000_01FF, 32'h0, 9'h0);
    chk("R6 irq drops after clear", {31'h0, irqOut}, {31'h0, expIrq(mEp, mEpEn, mCr, mCrEn)});
    verify("R6");

    // random mixed traffic
    for (int it = 0; it < 600; it++) begin
      logic [7:0]  a;
      logic [31:0] ev;
      logic [8:0]  cev;
      int op;
      op = $urandom % 7;
      ev = $urandom & $urandom & $urandom;
      cev = 9'($urandom & $urandom & $urandom);
      case (op)
        0: a = 8'h30; 1: a = 8'h34; 2: a = 8'h38; 3: a = 8'h3C;
        4: a = 8'h40; 5: a = 8'h44; default: a = 8'h18;
      endcase
      step((op != 6), a, $urandom & $urandom, ev, cev);
      if (it % 5 == 4) verify("R3 R5 random");
    end

    // R7 reset pulse
    step(1'b1, 8'h14, 32'h0000_0001, 32'h0, 9'h0);
    @(negedge clk);
    rd(8'h14, v); chk("R7 ctrl reads 1 during pulse", v, 32'h1);
    hi = 1;
    step(1'b1, 8'h14, 32'h0000_0001, 32'h0, 9'h0);
    hi++;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (coreRstOut) hi++;
    end
    chk("R7 pulse length", 32'(hi), 32'(RSTN));
    rd(8'h14, v); chk("R7 ctrl reads 0 after", v, 32'h0);

    // R8 phy otg disable
    step(1'b1, 8'hE0, 32'hFFFF_FFFF, 32'h0, 9'h0);
    @(negedge clk);
    rd(8'hE0, v); chk("R8 phy readback", v, 32'h0020_0000);
    chk("R8 otgDisable high", {31'h0, otgDisable}, 32'h1);
    step(1'b1, 8'hE0, 32'h0, 32'h0, 9'h0);
    chk("R8 otgDisable low", {31'h0, otgDisable}, 32'h0);

    // R9 id override
    idPin = 1'b0;
    step(1'b1, 8'hE8, 32'hFFFF_FFFF, 32'h0, 9'h0);
    @(negedge clk);
    rd(8'hE8, v); chk("R9 mode readback", v, 32'h0000_0180);
    chk("R9 override value 1", {31'h0, idSel}, 32'h1);
    step(1'b1, 8'hE8, 32'h0000_0080, 32'h0, 9'h0);
    idPin = 1'b1;
    #0.2;
    chk("R9 override value 0 ignores pin", {31'h0, idSel}, 32'h0);
    step(1'b1, 8'hE8, 32'h0, 32'h0, 9'h0);
    #0.2;
    chk("R9 pin passthrough 1", {31'h0, idSel}, 32'h1);
    idPin = 1'b0;
    #0.2;
    chk("R9 pin passthrough 0", {31'h0, idSel}, 32'h0);

    verify("final");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule